// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

This block takes the digital output of a supply comparator (high while the supply sits above its trip point) and turns it into a clean system reset. Short excursions of the comparator output are filtered out. Once the supply is judged good, the reset is held for a fixed power-up hold time before it is released. A drop of the supply asserts the reset again after a short, bounded delay. The reset is driven on two registered outputs of opposite polarity, and both always carry the same state.

An optional watchdog watches the serial data line of a two-wire bus. Every level change on that line, seen through a two-flop synchronizer, restarts the watchdog count. If the line stays quiet for a full watchdog window while the system is out of reset, the block asserts the reset for the same hold time used at power-up. It then releases the reset and starts a fresh window. A build parameter removes the watchdog completely. All lengths are parameters counted in clock cycles.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst` is high, `sys_rst_o` is 1 and `sys_rst_n_o` is 0. After `rst` falls, the reset stays asserted for as long as `supply_ok_i` stays 0.
- R2: A level of `supply_ok_i` that differs from the filtered level for fewer than `FILT_CYC` consecutive cycles has no effect on the reset outputs. A level that differs for `FILT_CYC` or more cycles is taken up.
- R3: After `supply_ok_i` rises and stays high, the reset is released exactly `2 + FILT_CYC + HOLD_CYC` clock cycles after the change.
- R4: After `supply_ok_i` falls and stays low, the reset asserts exactly `3 + FILT_CYC` clock cycles after the change.
- R5: `sys_rst_n_o` is always the inverse of `sys_rst_o`. Logic 1 on `sys_rst_o` means reset.
- R6: With `WDT_EN = 1` and no level change on `sda_i`, the reset asserts exactly `WDT_CYC` cycles after it was last released. It is then held for exactly `HOLD_CYC` cycles and released.
- R7: A level change on `sda_i` in either direction restarts the watchdog window. If changes keep arriving with gaps shorter than the window, the watchdog never asserts the reset.
- R8: The watchdog count is kept at zero while the reset is asserted. A new window is therefore always measured from the release of the reset.
- R9: With `WDT_EN = 0`, activity or silence on `sda_i` never asserts the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| supply_ok_i | input | 1 | Asynchronous comparator output, 1 = supply above trip point |
| sda_i | input | 1 | Asynchronous sense of the bus data line, watched for activity |
| sys_rst_o | output | 1 | Registered system reset, active high |
| sys_rst_n_o | output | 1 | Registered system reset, active low |

## Verification
The assertions assume that `supply_ok_i` and `sda_i` pass through the synchronizers before any check looks at them. They also assume that the filtered supply level changes only after the filter count has run out. The cycle-exact timing claims assume the inputs hold their new level for at least `FILT_CYC` cycles. The stimulus changes every asynchronous input only on the falling clock edge and holds each supply level for either a chosen glitch width or far longer than the filter. Bus activity is produced as regular toggles every 20 cycles or as single placed toggles, so every gap is known against the watchdog window.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Fixed depth of the input synchronizers
  localparam int unsigned SYNC_DEPTH = 2;

  // Supervisor phases
  typedef enum logic [0:0] {
    SUP_HOLD = 1'b0,   // reset asserted, hold timer may run
    SUP_RUN  = 1'b1    // reset released
  } sup_state_e;

  // Counter width able to hold values 0 .. lim-1
  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= RST_VAL;
          else     stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= RST_VAL;
          else     stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sup_deglitch.sv
module sup_deglitch
  import sup_pkg::*;
#(
  parameter int unsigned FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,    // synchronized level
  output logic q_o     // filtered level
);

  localparam int unsigned CW   = cnt_w(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (d_i != lvl_q) begin
      if (run_q == LAST) begin
        lvl_q <= d_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign q_o = lvl_q;

  // R2
  lvl_move_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> ($past(run_q) == LAST && $past(d_i) == lvl_q));

  // R2
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (d_i == lvl_q) |=> (run_q == '0));

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int unsigned WDT_CYC = 80_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_s_i,  // synchronized data line
  input  logic hold_i,   // reset currently asserted
  output logic bite_o    // one-cycle expiry request
);

  localparam int unsigned CW   = cnt_w(WDT_CYC);
  localparam logic [CW-1:0] LAST = CW'(WDT_CYC - 1);

  logic          sda_d_q;
  logic          act;
  logic [CW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) sda_d_q <= 1'b1;
    else     sda_d_q <= sda_s_i;
  end

  assign act    = sda_s_i ^ sda_d_q;
  assign bite_o = !hold_i && !act && (win_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || hold_i || act || bite_o) win_q <= '0;
    else                                win_q <= win_q + 1'b1;
  end

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (win_q == '0));

  // R7
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    act |=> (win_q == '0));

  // R6
  bite_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bite_o |-> (!hold_i && !act));

  // R6
  bite_restart_chk: assert property (@(posedge clk) disable iff (rst)
    bite_o |=> (win_q == '0));

endmodule

// File: rtl/sup_rstgen.sv
module sup_rstgen
  import sup_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_i,      // filtered supply level
  input  logic bite_i,    // watchdog expiry
  output logic in_rst_o,  // reset state for the watchdog
  output logic rst_o,
  output logic rst_n_o
);

  localparam int unsigned CW   = cnt_w(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  sup_state_e    st_q, st_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          rst_q, rst_n_q;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    if (!ok_i) begin
      st_d   = SUP_HOLD;
      hold_d = '0;
    end else if (st_q == SUP_HOLD) begin
      if (hold_q == LAST) begin
        st_d   = SUP_RUN;
        hold_d = '0;
      end else begin
        hold_d = hold_q + 1'b1;
      end
    end else if (bite_i) begin
      st_d   = SUP_HOLD;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SUP_HOLD;
      hold_q  <= '0;
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      hold_q  <= hold_d;
      rst_q   <= (st_d == SUP_HOLD);
      rst_n_q <= (st_d == SUP_RUN);
    end
  end

  assign in_rst_o = rst_q;
  assign rst_o    = rst_q;
  assign rst_n_o  = rst_n_q;

  // R4
  drop_assert_chk: assert property (@(posedge clk) disable iff (rst)
    !ok_i |=> rst_q);

  // R5
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q != rst_n_q);

  // R3
  release_ok_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_q) |-> $past(ok_i));

  // R6
  bite_assert_chk: assert property (@(posedge clk) disable iff (rst)
    bite_i |=> rst_q);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned FILT_CYC = 5,           // glitch filter length, cycles
  parameter int unsigned HOLD_CYC = 10_000_000,  // reset hold time, cycles
  parameter int unsigned WDT_CYC  = 80_000_000,  // watchdog window, cycles
  parameter bit          WDT_EN   = 1'b1         // 0 removes the watchdog
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic sda_i,
  output logic sys_rst_o,
  output logic sys_rst_n_o
);

  logic ok_s, ok_f;
  logic in_rst, bite;

  sup_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_ok_sync (
    .clk (clk),
    .rst (rst),
    .d_i (supply_ok_i),
    .q_o (ok_s)
  );

  sup_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk (clk),
    .rst (rst),
    .d_i (ok_s),
    .q_o (ok_f)
  );

  generate
    if (WDT_EN) begin : g_wdog
      logic sda_s;

      sup_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sda_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sda_i),
        .q_o (sda_s)
      );

      sup_wdog #(.WDT_CYC(WDT_CYC)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .sda_s_i (sda_s),
        .hold_i  (in_rst),
        .bite_o  (bite)
      );
    end else begin : g_no_wdog
      logic unused_sda;
      assign unused_sda = sda_i;
      assign bite       = 1'b0;
    end
  endgenerate

  sup_rstgen #(.HOLD_CYC(HOLD_CYC)) u_rstgen (
    .clk      (clk),
    .rst      (rst),
    .ok_i     (ok_f),
    .bite_i   (bite),
    .in_rst_o (in_rst),
    .rst_o    (sys_rst_o),
    .rst_n_o  (sys_rst_n_o)
  );

endmodule

// File: tb/supply_supervisor_bench.sv
module supply_supervisor_bench;

  localparam int F = 4;
  localparam int H = 40;
  localparam int W = 200;
  localparam int KICK_GAP = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply = 1'b0;
  logic sda = 1'b1;
  logic r_o, rn_o, nw_r, nw_rn;

  always #10 clk = ~clk;   // 50 MHz

  supply_supervisor #(.FILT_CYC(F), .HOLD_CYC(H), .WDT_CYC(W), .WDT_EN(1'b1))
    u_supply_supervisor (.clk(clk), .rst(rst), .supply_ok_i(supply), .sda_i(sda),
                         .sys_rst_o(r_o), .sys_rst_n_o(rn_o));

  supply_supervisor #(.FILT_CYC(F), .HOLD_CYC(H), .WDT_CYC(W), .WDT_EN(1'b0))
    u_nowd (.clk(clk), .rst(rst), .supply_ok_i(supply), .sda_i(sda),
            .sys_rst_o(nw_r), .sys_rst_n_o(nw_rn));

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit kick_en = 1'b0;
  int kc = 0;

  // Glitch table: low pulse width and whether the reset must react (R2)
  localparam int GL_N = 5;
  localparam int GL_W [GL_N] = '{1, F-2, F-1, F, F+2};
  localparam bit GL_E [GL_N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, act cycle %0d exp below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (kick_en) begin
      kc++;
      if (kc >= KICK_GAP) begin
        kc  = 0;
        sda = ~sda;
      end
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (r_o && n < 2000) begin
      step();
      n++;
    end
  endtask

  initial begin
    int n;
    bit saw, pol_bad;

    // R1: reset state
    repeat (4) step();
    chk(r_o == 1'b1 && rn_o == 1'b0, "R1 reset state", {r_o, rn_o}, 2'b10);
    rst = 1'b0;
    pol_bad = 1'b0;
    saw = 1'b0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (!r_o) saw = 1'b1;
      if (r_o == rn_o) pol_bad = 1'b1;
    end
    chk(!saw, "R1 held while supply low", !saw, 1);
    chk(!pol_bad, "R5 polarity during low supply", pol_bad, 0);

    // R3: release timing after supply rise
    kick_en = 1'b1;
    supply  = 1'b1;
    wait_release(n);
    chk(n == 2 + F + H, "R3 release latency", n, 2 + F + H);
    chk(rn_o == 1'b1, "R5 active-low released", rn_o, 1);

    // R2: glitch table walked by one loop
    for (int k = 0; k < GL_N; k++) begin
      saw = 1'b0;
      pol_bad = 1'b0;
      for (int i = 0; i < GL_W[k] + F + 8; i++) begin
        step();
        supply = (i < GL_W[k]) ? 1'b0 : 1'b1;
        if (r_o) saw = 1'b1;
        if (r_o == rn_o) pol_bad = 1'b1;
      end
      chk(saw == GL_E[k], "R2 glitch width response", saw, GL_E[k]);
      chk(!pol_bad, "R5 polarity during glitch", pol_bad, 0);
      if (GL_E[k]) wait_release(n);
    end

    // R4: fall latency
    step();
    supply = 1'b0;
    n = 0;
    while (!r_o && n < 500) begin
      step();
      n++;
    end
    chk(n == 3 + F, "R4 assert latency", n, 3 + F);
    chk(rn_o == 1'b0, "R5 active-low asserted", rn_o, 0);
    repeat (10) step();
    supply = 1'b1;
    wait_release(n);

    // R7: steady activity keeps the system out of reset
    saw = 1'b0;
    for (int i = 0; i < 4 * W; i++) begin
      step();
      if (r_o) saw = 1'b1;
    end
    chk(!saw, "R7 activity prevents expiry", saw, 0);

    // R6 / R8 / R9: quiet line, window measured from release
    kick_en = 1'b0;
    step();
    supply = 1'b0;
    repeat (F + 20) step();
    supply = 1'b1;
    wait_release(n);
    saw = 1'b0;
    n = 0;
    while (!r_o && n < 3 * W) begin
      step();
      n++;
      if (nw_r) saw = 1'b1;
    end
    chk(n == W, "R6 R8 expiry measured from release", n, W);
    n = 0;
    while (r_o && n < 3 * H) begin
      step();
      n++;
      if (nw_r) saw = 1'b1;
    end
    chk(n == H, "R6 expiry hold length", n, H);
    for (int i = 0; i < W + 20; i++) begin
      step();
      if (nw_r) saw = 1'b1;
    end
    chk(!saw, "R9 no watchdog when disabled", saw, 0);
    chk(r_o == 1'b1, "R6 second expiry on quiet line", r_o, 1);
    wait_release(n);

    // R7: single late toggles, falling then rising
    repeat (W - 10) step();
    sda = 1'b0;
    saw = 1'b0;
    for (int i = 0; i < W - 10; i++) begin
      step();
      if (r_o) saw = 1'b1;
    end
    sda = 1'b1;
    for (int i = 0; i < W - 10; i++) begin
      step();
      if (r_o) saw = 1'b1;
    end
    chk(!saw, "R7 single toggles restart window", saw, 0);
    n = 0;
    while (!r_o && n < 2 * W) begin
      step();
      n++;
    end
    chk(n == 10 + 3, "R7 expiry after last toggle", n, 13);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule